// File: doc/BRIEF.md
# Core-Banked Timer and Watchdog Aliasing Wrapper

This block gives every processor core of a small cluster one private interval timer and one watchdog-style countdown unit, and places them all behind a single 32-bit register port. The address space is cut into windows of 0x20 bytes. The two lowest windows are banked. Their target depends on a sideband core ID that travels with each request, so software on any core reaches its own timer and watchdog at the same addresses. The windows above them are fixed. Each one reaches one unit of one named core, so any core can inspect or program another core's units.

Each countdown unit has four registers: a reload value, a live counter, a control word with an enable bit and an auto-reload bit, and a sticky expiry flag that also drives the unit's interrupt line. The wrapper decodes the window and steers the access to one unit. It registers the response, returning read data or zero one cycle after the request, together with an error strobe when a banked access comes from a core that is not configured.

Top module: `mpt_banked_timers`

## Requirements
- R1: After reset every interrupt output is low and every register of every unit reads zero.
- R2: Each request cycle with req_valid high produces exactly one response cycle with rsp_valid high on the next clock; rsp_valid is low in cycles that follow no request.
- R3: Window 0 (byte addresses 0x000 to 0x01F) reaches the timer of the core named by req_core, and window 1 (0x020 to 0x03F) reaches that core's watchdog unit.
- R4: Window 2+2n (base 0x40+0x40·n) reaches the timer of core n, and window 3+2n reaches the watchdog unit of core n, whatever req_core is.
- R5: The interrupt vector is ordered by unit index: bit 2n is the timer of core n and bit 2n+1 is the watchdog unit of core n, each bit equal to that unit's expiry flag.
- R6: A banked-window access whose req_core is at or above NUM_CORES returns zero, changes no unit, and raises rsp_err in its response cycle only.
- R7: Fixed windows of cores at or above NUM_CORES, and windows beyond the last core's, return zero, change no unit and do not raise rsp_err.
- R8: An access with any byte enable low returns zero and changes no unit.
- R9: Register offsets within a window: 0x00 reload (a write also copies the value into the counter), 0x04 counter, 0x08 control (bit 0 enable, bit 1 auto-reload, other bits read zero), 0x0C expiry flag in bit 0 (writing 1 clears it). Any other offset, including unaligned ones, reads zero and ignores writes.
- R10: While enabled with a nonzero counter and not being written, a unit decrements its counter by one per clock. On the step from 1 to 0 it sets its expiry flag and, with auto-reload set, loads the reload value instead of 0. A disabled unit holds its counter.
- R11: A control write that turns on enable with auto-reload set while the counter is zero loads the reload value into the counter. Without auto-reload the counter stays zero and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window in the upper bits, register offset in bits 4:0 |
| req_be | input | DATA_W/8 | Byte enables; only all-ones is accepted |
| req_core | input | 2 | ID of the core issuing the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response cycle, one clock after the request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and rejected accesses |
| rsp_err | output | 1 | Banked access from an unconfigured core |
| irq | output | 2·NUM_CORES | Expiry flags in unit order |

## Verification
On every cycle, assertions check that at most one unit is written and that rejected requests (bad core, partial enables) write nothing. They also check that the error strobe comes with a zero response, that each request is answered on the next clock, and that inside each unit the flag only rises from a counter step from 1 to 0 and a disabled counter holds. The mapping of windows to units, the banked versus fixed aliasing seen from different cores, the interrupt bit order and the exact counter values after enabling can only be shown by the bench scenarios. Those scenarios compare read data against a reference model of the register file and run directed countdown sequences.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int unsigned MAX_CORES = 4;
  localparam int unsigned CORE_W    = 2;
  localparam int unsigned UNIT_W    = CORE_W + 1;
  localparam int unsigned OFF_W     = 5;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_AUTO = 1;
endpackage

// File: rtl/mpt_window_decode.sv
module mpt_window_decode
  import mpt_pkg::*;
#(
  parameter int unsigned NUM_CORES = 3,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned BE_W      = 4
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [CORE_W-1:0] req_core,
  output logic              sel_ok,
  output logic [UNIT_W-1:0] sel_unit,
  output logic              core_err
);
  localparam int unsigned WIN_W     = ADDR_W - OFF_W;
  localparam int unsigned NUM_UNITS = 2 * NUM_CORES;

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] fix_idx;
  logic             full_word;

  assign win       = req_addr[ADDR_W-1:OFF_W];
  assign fix_idx   = win - WIN_W'(2);
  assign full_word = &req_be;

  always_comb begin
    sel_ok   = 1'b0;
    sel_unit = '0;
    core_err = 1'b0;
    if (win < WIN_W'(2)) begin
      // banked windows: unit chosen by the requesting core
      if (int'(req_core) < int'(NUM_CORES)) begin
        sel_unit = {req_core, win[0]};
        sel_ok   = req_valid && full_word;
      end else begin
        core_err = req_valid;
      end
    end else if (int'(fix_idx) < int'(NUM_UNITS)) begin
      sel_unit = fix_idx[UNIT_W-1:0];
      sel_ok   = req_valid && full_word;
    end
  end
endmodule

// File: rtl/mpt_countdown.sv
module mpt_countdown
  import mpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] count_q,  count_d;
  logic [1:0]        ctrl_q,   ctrl_d;
  logic              flag_q,   flag_d;
  logic              running;
  logic              upd_en;

  assign running = ctrl_q[CTRL_EN] && (count_q != '0);
  assign upd_en  = wr_en || running;

  always_comb begin
    reload_d = reload_q;
    count_d  = count_q;
    ctrl_d   = ctrl_q;
    flag_d   = flag_q;
    if (wr_en) begin
      unique case (reg_sel)
        REG_RELOAD: begin
          reload_d = wdata;
          count_d  = wdata;
        end
        REG_COUNT: count_d = wdata;
        REG_CTRL: begin
          ctrl_d = wdata[1:0];
          if (!ctrl_q[CTRL_EN] && wdata[CTRL_EN] && wdata[CTRL_AUTO] && (count_q == '0))
            count_d = reload_q;
        end
        REG_FLAG: if (wdata[0]) flag_d = 1'b0;
        default: ;
      endcase
    end else if (running) begin
      count_d = count_q - DATA_W'(1);
      if (count_q == DATA_W'(1)) begin
        flag_d = 1'b1;
        if (ctrl_q[CTRL_AUTO]) count_d = reload_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else if (upd_en) begin
      reload_q <= reload_d;
      count_q  <= count_d;
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      REG_RELOAD: rdata = reload_q;
      REG_COUNT:  rdata = count_q;
      REG_CTRL:   rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
      REG_FLAG:   rdata = {{(DATA_W-1){1'b0}}, flag_q};
      default:    rdata = '0;
    endcase
  end

  assign irq = flag_q;

  // R10: the flag only rises on an enabled step from 1 to 0
  p_flag_from_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(count_q) == DATA_W'(1)) && $past(ctrl_q[CTRL_EN]));

  // R10: a disabled, unwritten unit keeps its counter
  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_EN] && !wr_en) |=> $stable(count_q));

  // R11: enabling with auto-reload from a zero counter reloads it
  p_enable_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_CTRL && !ctrl_q[CTRL_EN] && wdata[CTRL_EN] &&
     wdata[CTRL_AUTO] && count_q == '0) |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/mpt_banked_timers.sv
module mpt_banked_timers
  import mpt_pkg::*;
#(
  parameter int unsigned NUM_CORES = 3,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W/8-1:0]    req_be,
  input  logic [CORE_W-1:0]      req_core,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_err,
  output logic [2*NUM_CORES-1:0] irq
);
  localparam int unsigned NUM_UNITS = 2 * NUM_CORES;
  localparam int unsigned BE_W      = DATA_W / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic              sel_ok;
  logic [UNIT_W-1:0] sel_unit;
  logic              core_err;
  logic              reg_ok;
  reg_sel_e          reg_sel;

  mpt_window_decode #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .BE_W      (BE_W)
  ) u_decode (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_core  (req_core),
    .sel_ok    (sel_ok),
    .sel_unit  (sel_unit),
    .core_err  (core_err)
  );

  assign reg_ok  = (req_addr[4] == 1'b0) && (req_addr[1:0] == 2'b00);
  assign reg_sel = reg_sel_e'(req_addr[3:2]);

  logic [NUM_UNITS-1:0] unit_wr;
  logic [DATA_W-1:0]    unit_rdata [NUM_UNITS];

  always_comb begin
    for (int i = 0; i < int'(NUM_UNITS); i++)
      unit_wr[i] = sel_ok && req_write && reg_ok && (sel_unit == UNIT_W'(i));
  end

  for (genvar g = 0; g < int'(NUM_UNITS); g++) begin : g_unit
    mpt_countdown #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (unit_wr[g]),
      .reg_sel (reg_sel),
      .wdata   (req_wdata),
      .rdata   (unit_rdata[g]),
      .irq     (irq[g])
    );
  end

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rsp_rdata_d;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < int'(NUM_UNITS); i++)
      if (sel_unit == UNIT_W'(i)) rd_mux = unit_rdata[i];
    rsp_rdata_d = (sel_ok && !req_write && reg_ok) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rsp_rdata_d;
      rsp_err   <= core_err;
    end
  end

  // R3: one access writes at most one unit
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(unit_wr));

  // R6: a rejected core ID writes nothing
  p_bad_core_no_write_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    core_err |-> (unit_wr == '0));

  // R6: the error strobe rides on a zero response
  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  // R8: partial enables write nothing
  p_partial_no_write_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !(&req_be)) |-> (unit_wr == '0));

  // R2: every request is answered on the next clock
  p_rsp_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/tb_mpt_banked_timers.sv
module tb_mpt_banked_timers;
  localparam int NC = 3;
  localparam int NU = 2 * NC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [8:0]  req_addr;
  logic [3:0]  req_be;
  logic [1:0]  req_core;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [NU-1:0] irq;

  always #2 clk = ~clk;

  mpt_banked_timers #(.NUM_CORES(NC), .ADDR_W(9), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_core(req_core),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_reload [NU];
  logic [31:0] m_count  [NU];
  logic [1:0]  m_ctrl   [NU];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] wa(input int w, input int off);
    return 9'(w * 32 + off);
  endfunction

  // unit reached by a window/core pair, -1 if none
  function automatic int exp_unit(input int w, input int core);
    if (w < 2) return (core < NC) ? 2 * core + w : -1;
    if (w - 2 < NU) return w - 2;
    return -1;
  endfunction

  function automatic bit off_ok(input int off);
    return (off < 16) && (off % 4 == 0);
  endfunction

  function automatic logic [31:0] exp_reg(input int u, input int off);
    case (off)
      0:  return m_reload[u];
      4:  return m_count[u];
      8:  return {30'd0, m_ctrl[u]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic acc(input bit wr, input logic [8:0] addr, input logic [3:0] be,
                     input logic [1:0] core, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle response", 32'(rsp_valid), 32'd0);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be;
    req_core = core; req_wdata = wd;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 response", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; er = rsp_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    req_valid = 0; req_write = 0; req_addr = 0; req_be = 0; req_core = 0; req_wdata = 0;
    rst_n = 1'b0;
    for (int u = 0; u < NU; u++) begin m_reload[u] = 0; m_count[u] = 0; m_ctrl[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(irq == '0, "R1 irq after reset", 32'(irq), 32'd0);
    for (int u = 0; u < NU; u++)
      for (int o = 0; o < 16; o += 4) begin
        acc(0, wa(u + 2, o), 4'hF, 2'd0, 0, rd, er);
        chk(rd == 0, "R1 register after reset", rd, 0);
      end

    // random register traffic, no unit ever enabled
    void'($urandom(32'd7151));
    for (int k = 0; k < 500; k++) begin
      int w, core, off, u;
      bit wr, act, bad;
      logic [3:0] be;
      logic [31:0] wd, ex;
      string tag;
      w    = $urandom_range(0, 15);
      core = $urandom_range(0, 3);
      case ($urandom_range(0, 7))
        0: off = 0; 1: off = 4; 2: off = 8; 3: off = 12;
        4: off = 16; 5: off = 20; 6: off = 2; default: off = 28;
      endcase
      be = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      wr = 1'($urandom_range(0, 1));
      wd = $urandom & 32'hFFFF_FFFE;
      u   = exp_unit(w, core);
      bad = (w < 2) && (core >= NC);
      act = (u >= 0) && (be == 4'hF) && off_ok(off);
      ex  = (act && !wr) ? exp_reg(u, off) : 32'd0;
      if (bad)                 tag = "R6 bad core";
      else if (be != 4'hF)     tag = "R8 partial enables";
      else if (u < 0)          tag = "R7 absent window";
      else if (!off_ok(off))   tag = "R9 unused offset";
      else if (w < 2)          tag = "R3 banked window";
      else                     tag = "R4 fixed window";
      acc(wr, wa(w, off), be, 2'(core), wd, rd, er);
      chk(rd == ex, tag, rd, ex);
      chk(er == bad, {tag, " error strobe"}, 32'(er), 32'(bad));
      if (act && wr) begin
        case (off)
          0: begin m_reload[u] = wd; m_count[u] = wd; end
          4: m_count[u] = wd;
          8: m_ctrl[u] = wd[1:0];
          default: ;
        endcase
      end
    end
    chk(irq == '0, "R5 irq quiet while disabled", 32'(irq), 0);

    // R6: error strobe lasts one response only
    acc(1, wa(0, 0), 4'hF, 2'd3, 32'hDEAD, rd, er);
    chk(er == 1, "R6 bad core write flags error", 32'(er), 1);
    @(negedge clk);
    chk(rsp_err == 0, "R6 error gone next cycle", 32'(rsp_err), 0);
    acc(0, wa(2, 0), 4'hF, 2'd3, 0, rd, er);
    chk(rd == m_reload[0] && er == 0, "R4 fixed window for core 3 requester", rd, m_reload[0]);

    // R8: partial write leaves the reload value
    acc(1, wa(7, 0), 4'h3, 2'd0, 32'h1234_5678, rd, er);
    acc(0, wa(7, 0), 4'hF, 2'd0, 0, rd, er);
    chk(rd == m_reload[5], "R8 partial write ignored", rd, m_reload[5]);

    // R10: one-shot countdown on core 0 timer via banked window
    acc(1, wa(0, 8), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 0), 4'hF, 2'd0, 5, rd, er);
    acc(1, wa(0, 8), 4'hF, 2'd0, 1, rd, er);
    repeat (20) @(negedge clk);
    acc(0, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 0, "R10 one-shot ends at zero", rd, 0);
    acc(0, wa(2, 12), 4'hF, 2'd2, 0, rd, er);
    chk(rd == 1, "R10 flag set at expiry", rd, 1);
    chk(irq == 6'b000001, "R5 timer core 0 on bit 0", 32'(irq), 32'h1);
    acc(1, wa(0, 12), 4'hF, 2'd0, 1, rd, er);
    acc(0, wa(0, 12), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 0, "R9 flag write-one clears", rd, 0);
    chk(irq == '0, "R9 irq drops after clear", 32'(irq), 0);

    // R10: exact decrement rate
    acc(1, wa(0, 8), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 0), 4'hF, 2'd0, 1000, rd, er);
    acc(1, wa(0, 8), 4'hF, 2'd0, 1, rd, er);
    acc(0, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 999, "R10 one step per clock", rd, 999);

    // R11: enable with auto-reload from zero loads the reload value
    acc(1, wa(0, 8), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 0), 4'hF, 2'd0, 50, rd, er);
    acc(1, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 8), 4'hF, 2'd0, 3, rd, er);
    acc(0, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 49, "R11 auto-reload on enable", rd, 49);
    acc(1, wa(0, 8), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(0, 8), 4'hF, 2'd0, 1, rd, er);
    acc(0, wa(0, 4), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 0, "R11 no reload without auto", rd, 0);
    acc(0, wa(0, 12), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 0, "R11 no flag without auto", rd, 0);

    // R10/R5: periodic watchdog of core 1 through its fixed window
    acc(1, wa(5, 8), 4'hF, 2'd0, 0, rd, er);
    acc(1, wa(5, 0), 4'hF, 2'd0, 3, rd, er);
    acc(1, wa(5, 8), 4'hF, 2'd0, 3, rd, er);
    repeat (20) @(negedge clk);
    chk(irq == 6'b001000, "R5 watchdog core 1 on bit 3", 32'(irq), 32'h8);
    acc(0, wa(5, 4), 4'hF, 2'd0, 0, rd, er);
    chk(rd >= 1 && rd <= 3, "R10 auto-reload keeps counting", rd, 3);
    acc(0, wa(1, 12), 4'hF, 2'd1, 0, rd, er);
    chk(rd == 1, "R3 banked watchdog of core 1", rd, 1);
    acc(0, wa(1, 12), 4'hF, 2'd0, 0, rd, er);
    chk(rd == 0, "R3 banked watchdog of core 0", rd, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule